// File: doc/BRIEF.md
# Remappable Address Window Decoder

This block holds a bank of programmable decode windows that steer a 36-bit physical request address to a device. Each device is named by a 4-bit target and an 8-bit attribute. Software programs every window through a plain 32-bit register port. The lookup side is purely combinational: it returns whether any window claimed the address, the device identity of the winning window, and the address after translation.

Windows come in two kinds. The low-numbered windows carry a remap register pair. When one of them claims a request, the upper address bits outside the window's size mask are replaced with programmed values. The remaining windows hand the address on untouched.

The register space is split into two regions with different strides. A reserved hole sits between the two regions. Writes are stored on the clock edge. Reads and lookups always reflect the stored state combinationally.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register offset reads zero and no lookup address hits.
- R2: Window w below 8 occupies offsets w*16 to w*16+15: control at +0, base at +4, remap-low at +8, remap-high at +12.
- R3: Window w from 8 to 19 occupies offset 0x90+(w-8)*8, with control at +0 and base at +4. Offsets 0xF0 and above read zero, and writes to them are ignored.
- R4: Offsets 0x80 to 0x8F read zero, and writes to them change nothing.
- R5: Control bit 0 is enable, bits 7:4 are target, bits 15:8 are attribute, and bits 31:16 hold (size-1) in 64 KB units. All 32 bits read back exactly as written.
- R6: The base register keeps address bits 31:16 in bits 31:16 and address bits 35:32 in bits 3:0; its other bits read zero. Remap-low keeps bits 31:16 only. Remap-high keeps bits 3:0 only.
- R7: A write becomes visible on both the read port and the lookup port in the cycle after its clock edge. In the write cycle itself, the old state is used.
- R8: An enabled window hits when address bits 35:32 equal its base bits 35:32 and address bits 31:16, ignoring the bits set in the size field, equal its base bits 31:16 with the same bits ignored.
- R9: A window whose enable bit is clear, including after its control register is written with zero, never hits.
- R10: When several windows hit, the lowest-numbered one supplies the target, the attribute and the output address.
- R11: On a hit by a window below 8, the output address is formed as follows. Bits 35:32 come from remap-high bits 3:0. Bits 31:16 take remap-low where the size field is 0 and the request address where it is 1. Bits 15:0 come from the request address.
- R12: On a hit by a window from 8 to 19, the output address equals the request address.
- R13: When no window hits, the hit flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at reg_addr (combinational) |
| lk_addr | input | 36 | Lookup request address |
| lk_hit | output | 1 | Some enabled window claims lk_addr |
| lk_target | output | 4 | Target of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_addr_out | output | 36 | Translated address |

## Verification
A register write and a lookup can land in the same cycle and address the very same window, for example a disable or a remap change issued while that window is being looked up. The bench provokes this on purpose: it clears window 0's control register while presenting an address inside window 0. It also mixes random writes with random lookups. Its reference model applies each write only after comparing that cycle's outputs, so it expects the old routing in the write cycle and the new routing one cycle later.

// File: rtl/awd_pkg.sv
package awd_pkg;
   localparam int ADDR_W = 36;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_RLO  = 2'd2,
      SEL_RHI  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic        en;
      logic [3:0]  tgt;
      logic [7:0]  attr;
      logic [15:0] mask;
      logic [15:0] base_lo;
      logic [3:0]  base_hi;
   } win_cfg_t;

   typedef struct packed {
      logic [15:0] lo;
      logic [3:0]  hi;
   } remap_t;
endpackage

// File: rtl/awd_regdec.sv
module awd_regdec
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int REG_AW    = 8,
   localparam int WIN_IW   = $clog2(NUM_WIN)
) (
   input  logic [REG_AW-1:0] off,
   output logic              valid,
   output logic [WIN_IW-1:0] win,
   output reg_sel_e          sel
);
   localparam int HOLE_LO = NUM_REMAP * 16;
   localparam int HOLE_HI = HOLE_LO + 16;
   localparam int TOP_OFF = HOLE_HI + (NUM_WIN - NUM_REMAP) * 8;

   logic [31:0] o32;
   logic [31:0] rel;

   always_comb begin
      o32   = 32'(off);
      rel   = o32 - 32'(HOLE_HI);
      valid = 1'b0;
      win   = '0;
      sel   = SEL_CTRL;
      if (o32 < 32'(HOLE_LO)) begin
         valid = 1'b1;
         win   = WIN_IW'(o32 >> 4);
         sel   = reg_sel_e'(o32[3:2]);
      end else if (o32 >= 32'(HOLE_HI) && o32 < 32'(TOP_OFF)) begin
         valid = 1'b1;
         win   = WIN_IW'(32'(NUM_REMAP) + (rel >> 3));
         sel   = rel[2] ? SEL_BASE : SEL_CTRL;
      end
   end
endmodule

// File: rtl/awd_regfile.sv
module awd_regfile
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int REG_AW    = 8,
   localparam int WIN_IW   = $clog2(NUM_WIN),
   localparam int RIW      = $clog2(NUM_REMAP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output win_cfg_t          cfg   [NUM_WIN],
   output remap_t            remap [NUM_REMAP]
);
   logic [31:0] ctrl_q [NUM_WIN];
   logic [15:0] blo_q  [NUM_WIN];
   logic [3:0]  bhi_q  [NUM_WIN];
   logic [15:0] rlo_q  [NUM_REMAP];
   logic [3:0]  rhi_q  [NUM_REMAP];

   logic              dec_valid;
   logic [WIN_IW-1:0] dec_win;
   reg_sel_e          dec_sel;
   logic [RIW-1:0]    ridx;

   awd_regdec #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
   ) u_dec (
      .off(addr), .valid(dec_valid), .win(dec_win), .sel(dec_sel)
   );

   assign ridx = dec_win[RIW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int w = 0; w < NUM_WIN; w++) begin
            ctrl_q[w] <= '0;
            blo_q[w]  <= '0;
            bhi_q[w]  <= '0;
         end
         for (int r = 0; r < NUM_REMAP; r++) begin
            rlo_q[r] <= '0;
            rhi_q[r] <= '0;
         end
      end else if (we && dec_valid) begin
         unique case (dec_sel)
            SEL_CTRL: ctrl_q[dec_win] <= wdata;
            SEL_BASE: begin
               blo_q[dec_win] <= wdata[31:16];
               bhi_q[dec_win] <= wdata[3:0];
            end
            SEL_RLO:  rlo_q[ridx] <= wdata[31:16];
            SEL_RHI:  rhi_q[ridx] <= wdata[3:0];
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (dec_valid) begin
         unique case (dec_sel)
            SEL_CTRL: rdata = ctrl_q[dec_win];
            SEL_BASE: rdata = {blo_q[dec_win], 12'h000, bhi_q[dec_win]};
            SEL_RLO:  rdata = {rlo_q[ridx], 16'h0000};
            SEL_RHI:  rdata = {28'h0, rhi_q[ridx]};
         endcase
      end
   end

   always_comb begin
      for (int w = 0; w < NUM_WIN; w++) begin
         cfg[w].en      = ctrl_q[w][0];
         cfg[w].tgt     = ctrl_q[w][7:4];
         cfg[w].attr    = ctrl_q[w][15:8];
         cfg[w].mask    = ctrl_q[w][31:16];
         cfg[w].base_lo = blo_q[w];
         cfg[w].base_hi = bhi_q[w];
      end
      for (int r = 0; r < NUM_REMAP; r++) begin
         remap[r].lo = rlo_q[r];
         remap[r].hi = rhi_q[r];
      end
   end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
   import awd_pkg::*;
(
   input  win_cfg_t          cfg,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic hi_eq;
   logic lo_eq;

   assign hi_eq = (addr[35:32] == cfg.base_hi);
   assign lo_eq = ((addr[31:16] & ~cfg.mask) == (cfg.base_lo & ~cfg.mask));
   assign hit   = cfg.en & hi_eq & lo_eq;
endmodule

// File: rtl/awd_pick.sv
module awd_pick
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   localparam int WIN_IW   = $clog2(NUM_WIN),
   localparam int RIW      = $clog2(NUM_REMAP)
) (
   input  logic [NUM_WIN-1:0] hit_vec,
   input  win_cfg_t           cfg   [NUM_WIN],
   input  remap_t             remap [NUM_REMAP],
   input  logic [ADDR_W-1:0]  addr,
   output logic               hit,
   output logic [WIN_IW-1:0]  idx,
   output logic [3:0]         target,
   output logic [7:0]         attr,
   output logic [ADDR_W-1:0]  addr_out
);
   win_cfg_t sel_cfg;
   remap_t   sel_rm;

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            hit = 1'b1;
            idx = WIN_IW'(i);
         end
      end
   end

   assign sel_cfg = cfg[idx];
   assign sel_rm  = remap[idx[RIW-1:0]];
   assign target  = sel_cfg.tgt;
   assign attr    = sel_cfg.attr;

   always_comb begin
      addr_out = addr;
      if (32'(idx) < 32'(NUM_REMAP)) begin
         addr_out[35:32] = sel_rm.hi;
         addr_out[31:16] = (sel_rm.lo & ~sel_cfg.mask) | (addr[31:16] & sel_cfg.mask);
      end
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int REG_AW    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [3:0]        lk_target,
   output logic [7:0]        lk_attr,
   output logic [ADDR_W-1:0] lk_addr_out
);
   localparam int WIN_IW  = $clog2(NUM_WIN);
   localparam int MAP_END = NUM_REMAP * 16 + 16 + (NUM_WIN - NUM_REMAP) * 8;

   if (NUM_REMAP < 2 || NUM_REMAP >= NUM_WIN) begin : g_bad_split
      $error("NUM_REMAP must be at least 2 and below NUM_WIN");
   end
   if (MAP_END > (1 << REG_AW)) begin : g_bad_aw
      $error("REG_AW too narrow for the register map");
   end

   win_cfg_t          cfg   [NUM_WIN];
   remap_t            remap [NUM_REMAP];
   logic [NUM_WIN-1:0] hit_vec;
   logic [NUM_WIN-1:0] en_vec;
   logic [WIN_IW-1:0]  win_idx;

   awd_regfile #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg), .remap(remap)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      awd_win_match u_match (
         .cfg(cfg[w]), .addr(lk_addr), .hit(hit_vec[w])
      );
      assign en_vec[w] = cfg[w].en;
   end

   awd_pick #(
      .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)
   ) u_pick (
      .hit_vec(hit_vec), .cfg(cfg), .remap(remap), .addr(lk_addr),
      .hit(lk_hit), .idx(win_idx), .target(lk_target), .attr(lk_attr),
      .addr_out(lk_addr_out)
   );
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int NUM_WIN   = 20,
   parameter int NUM_REMAP = 8,
   parameter int REG_AW    = 8,
   localparam int WIN_IW   = $clog2(NUM_WIN)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_we,
   input logic [REG_AW-1:0]  reg_addr,
   input logic [31:0]        reg_wdata,
   input logic [31:0]        reg_rdata,
   input logic [35:0]        lk_addr,
   input logic               lk_hit,
   input logic [35:0]        lk_addr_out,
   input logic [NUM_WIN-1:0] hit_vec,
   input logic [NUM_WIN-1:0] en_vec,
   input logic [WIN_IW-1:0]  win_idx
);
   localparam int HOLE_LO = NUM_REMAP * 16;
   localparam int HOLE_HI = HOLE_LO + 16;

   logic [NUM_WIN-1:0] below_mask;
   assign below_mask = (NUM_WIN'(1) << win_idx) - NUM_WIN'(1);

   assert_disabled_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> en_vec[win_idx]);

   assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (hit_vec[win_idx] && ((hit_vec & below_mask) == '0)));

   assert_passthru_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && 32'(win_idx) >= 32'(NUM_REMAP)) |-> (lk_addr_out == lk_addr));

   assert_miss_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (hit_vec == '0));

   assert_hole_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_addr) >= 32'(HOLE_LO) && 32'(reg_addr) < 32'(HOLE_HI)) |-> (reg_rdata == '0));

   assert_write_visible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == '0) |=> (reg_addr != '0 || reg_rdata == $past(reg_wdata)));
endmodule

bind addr_window_decoder awd_checker #(
   .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
   .lk_hit(lk_hit), .lk_addr_out(lk_addr_out), .hit_vec(hit_vec),
   .en_vec(en_vec), .win_idx(win_idx)
);

// File: tb/addr_window_decoder_tb.sv
module addr_window_decoder_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [35:0] lk_addr = '0;
   logic        lk_hit;
   logic [3:0]  lk_target;
   logic [7:0]  lk_attr;
   logic [35:0] lk_addr_out;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   addr_window_decoder u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr),
      .lk_addr_out(lk_addr_out)
   );

   // reference state
   logic [31:0] m_ctrl [20];
   logic [15:0] m_blo  [20];
   logic [3:0]  m_bhi  [20];
   logic [15:0] m_rlo  [8];
   logic [3:0]  m_rhi  [8];

   function automatic bit m_decode(int off, output int w, output int s);
      w = 0; s = 0;
      if (off < 128) begin w = off / 16; s = (off % 16) / 4; return 1; end
      if (off >= 144 && off < 240) begin
         w = 8 + (off - 144) / 8; s = ((off - 144) % 8) / 4; return 1;
      end
      return 0;
   endfunction

   function automatic logic [31:0] m_read(int off);
      int w, s;
      if (!m_decode(off, w, s)) return 32'h0;
      case (s)
         0: return m_ctrl[w];
         1: return {m_blo[w], 12'h0, m_bhi[w]};
         2: return {m_rlo[w], 16'h0};
         default: return {28'h0, m_rhi[w]};
      endcase
   endfunction

   task automatic m_write(int off, logic [31:0] d);
      int w, s;
      if (!m_decode(off, w, s)) return;
      case (s)
         0: m_ctrl[w] = d;
         1: begin m_blo[w] = d[31:16]; m_bhi[w] = d[3:0]; end
         2: m_rlo[w] = d[31:16];
         default: m_rhi[w] = d[3:0];
      endcase
   endtask

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic compare(int off, string rtag, string ltag);
      longint a, base, size, rb;
      int win;
      logic [35:0] exp_out;
      a = longint'(lk_addr);
      win = -1;
      for (int w = 0; w < 20; w++) begin
         if (win < 0 && m_ctrl[w][0]) begin
            size = (longint'(m_ctrl[w][31:16]) + 1) << 16;
            base = (longint'(m_bhi[w]) << 32) | (longint'(m_blo[w]) << 16);
            if (a >= base && a < base + size) win = w;
         end
      end
      chk(reg_rdata == m_read(off), rtag, 64'(reg_rdata), 64'(m_read(off)));
      chk(lk_hit == (win >= 0), {ltag, " hit"}, 64'(lk_hit), 64'(win >= 0));
      if (win >= 0 && lk_hit) begin
         base = (longint'(m_bhi[win]) << 32) | (longint'(m_blo[win]) << 16);
         if (win < 8) begin
            rb = (longint'(m_rhi[win]) << 32) | (longint'(m_rlo[win]) << 16);
            exp_out = 36'(rb + (a - base));
         end else begin
            exp_out = 36'(a);
         end
         chk(lk_target == m_ctrl[win][7:4], {ltag, " target"}, 64'(lk_target), 64'(m_ctrl[win][7:4]));
         chk(lk_attr == m_ctrl[win][15:8], {ltag, " attr"}, 64'(lk_attr), 64'(m_ctrl[win][15:8]));
         chk(lk_addr_out == exp_out, {ltag, " addr"}, 64'(lk_addr_out), 64'(exp_out));
      end
   endtask

   task automatic cyc(bit we, int off, logic [31:0] wd, logic [35:0] la,
                      string rtag, string ltag);
      @(negedge clk);
      reg_we = we; reg_addr = 8'(off); reg_wdata = wd; lk_addr = la;
      #1;
      compare(off, rtag, ltag);
      @(posedge clk);
      if (we) m_write(off, wd);
   endtask

   function automatic logic [7:0] pick_byte(int k);
      case (k)
         0: return 8'h10;
         1: return 8'h20;
         default: return 8'h21;
      endcase
   endfunction

   initial begin
      for (int w = 0; w < 20; w++) begin m_ctrl[w] = 0; m_blo[w] = 0; m_bhi[w] = 0; end
      for (int r = 0; r < 8; r++) begin m_rlo[r] = 0; m_rhi[r] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: every offset reads zero, nothing hits
      for (int off = 0; off < 256; off += 4)
         cyc(0, off, 0, 36'(off) << 16, "R1 reset read", "R1 reset lookup");

      // R2 R5 R6: window 0, remappable
      cyc(1, 8'h00, 32'h000F_5A31, 0, "R2 ctrl", "R13");
      cyc(1, 8'h04, 32'hABCD_FFF1, 0, "R2 base", "R13");
      cyc(1, 8'h08, 32'h4560_1234, 0, "R2 rlo", "R13");
      cyc(1, 8'h0C, 32'hFFFF_FFF2, 0, "R2 rhi", "R13");
      cyc(1, 8'h04, 32'h2000_0001, 0, "R6 base readback", "R13");
      cyc(0, 8'h08, 0, 36'h1_2003_4567, "R6 rlo readback", "R11 remap");
      cyc(0, 8'h0C, 0, 36'h1_200F_FFFF, "R6 rhi readback", "R11 remap edge");
      cyc(0, 8'h00, 0, 36'h1_2010_0000, "R5 ctrl readback", "R8 just past");

      // R3: window 9, large, non-remappable, overlaps window 0
      cyc(1, 8'h98, 32'h00FF_C371, 0, "R3 ctrl", "R13");
      cyc(1, 8'h9C, 32'h2000_0001, 36'h1_2003_4567, "R3 base", "R10 overlap");
      cyc(0, 8'h98, 0, 36'h1_2003_4567, "R3 ctrl readback", "R10 low wins");
      cyc(0, 8'h9C, 0, 36'h1_20A0_0010, "R3 base readback", "R12 passthru");
      cyc(0, 8'h9C, 0, 36'h0_20A0_0010, "R3 base readback", "R8 hi mismatch");

      // R4: hole writes ignored; R3: beyond-map writes ignored
      cyc(1, 8'h84, 32'hFFFF_FFFF, 36'h1_2003_4567, "R4 hole", "R4 lookup");
      cyc(0, 8'h84, 0, 36'h1_2003_4567, "R4 hole read", "R4 lookup after");
      cyc(1, 8'hF0, 32'hFFFF_FFFF, 0, "R3 beyond", "R13");
      cyc(0, 8'hF0, 0, 0, "R3 beyond read", "R13");

      // R6: base register unused bits
      cyc(1, 8'hB4, 32'hFFFF_FFFF, 0, "R6 base w12", "R13");
      cyc(0, 8'hB4, 0, 0, "R6 base w12 read", "R9 w12 disabled");

      // R7 R9: disable window 0 in the same cycle as a lookup hitting it
      cyc(1, 8'h00, 32'h0, 36'h1_2003_4567, "R7 write cycle", "R7 old state");
      cyc(0, 8'h00, 0, 36'h1_2003_4567, "R9 ctrl zero", "R9 disabled");

      // random mix
      for (int n = 0; n < 4000; n++) begin
         int w, s, off;
         logic [31:0] d;
         logic [35:0] la;
         bit we;
         w = $urandom_range(0, 19);
         s = (w < 8) ? $urandom_range(0, 3) : $urandom_range(0, 1);
         off = (w < 8) ? w * 16 + s * 4 : 144 + (w - 8) * 8 + s * 4;
         if ($urandom_range(0, 15) == 0) off = 4 * $urandom_range(32, 35);
         if ($urandom_range(0, 15) == 0) off = 4 * $urandom_range(60, 63);
         d = $urandom;
         case (s)
            0: begin
               case ($urandom_range(0, 3))
                  0: d[31:16] = 16'h0000;
                  1: d[31:16] = 16'h0001;
                  2: d[31:16] = 16'h000F;
                  default: d[31:16] = 16'h00FF;
               endcase
            end
            1: begin
               d[31:24] = pick_byte($urandom_range(0, 2));
               d[23:16] = 8'h00;
               d[3:0]   = 4'($urandom_range(0, 1));
            end
            2: d[23:16] = 8'h00;
            default: ;
         endcase
         we = ($urandom_range(0, 2) != 0);
         la = {4'($urandom_range(0, 1)), pick_byte($urandom_range(0, 2)), 24'($urandom)};
         cyc(we, off, d, la, "R5 R6 R7 random read", "R8 R10 R11 R12 random");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule